// File: doc/BRIEF.md
# Block-Counted Word Buffer with Level Requests

This block sits between a host data register and a byte-wide card stream. It stores 16-bit words in a 32-entry circular buffer. The host pushes and pops whole words. The card side moves one byte per handshake. Two card bytes make one word, low byte first. A byte counter and a block counter run against a programmed block length and block count, and the transfer stops when the last byte of the last block has moved.

Each direction watches the fill level against its own threshold. A receive transfer compares the fill against an almost-full level. A transmit transfer compares it against an almost-empty level. When the comparison holds, the block raises either a DMA request or a status flag for that direction, chosen by that direction's DMA enable. Software sets the thresholds and enables with one configuration word. A transfer starts with a start pulse and a direction bit.

Top module: `blk_word_fifo`

## Requirements
- R1: After reset the fill count is 0, `busy` and `xfer_done` are 0, the card handshakes, DMA requests and level flags are all low, and `bytes_left` and `blocks_left` both read 1.
- R2: The buffer holds 32 words with wrapping read and write positions. A host write to a full buffer is dropped: the fill stays 32 and the stored words are unchanged.
- R3: A host read of an empty buffer returns the entry at the current read position, and the fill count stays 0.
- R4: In a receive transfer, the first byte of a word lands in bits 7:0 and the second byte in bits 15:8. If the first byte is the last byte of its block, the word is committed at once with bits 15:8 zero.
- R5: In a transmit transfer, each word is sent as bits 7:0 and then bits 15:8. The high byte is skipped when the low byte was the last byte of its block.
- R6: In a receive transfer, `card_rx_ready` is low at the start of a word while the fill count is above the almost-full level.
- R7: In a transmit transfer, `card_tx_valid` stays low while the buffer is empty.
- R8: Writing the block length loads the field plus one into both the length and `bytes_left`. Writing the block count loads the field plus one into `blocks_left` and reloads `bytes_left` from the stored length.
- R9: When a block's last byte moves, `blocks_left` drops by one and `bytes_left` reloads. After the final block, `blocks_left` reloads, `busy` falls and `xfer_done` sets.
- R10: During a receive transfer with the fill above the almost-full level, `dma_rx_req` is high when receive DMA is enabled, and `flag_rx_level` is high otherwise. When the condition is false, both are low.
- R11: During a transmit transfer with the fill below the almost-empty level, `dma_tx_req` is high when transmit DMA is enabled, and `flag_tx_level` is high otherwise. When the condition is false, both are low.
- R12: With no transfer active and an empty buffer, all four request and flag outputs are low.
- R13: The configuration word holds these fields: bit 15 enables receive DMA, bits 12:8 set the almost-full level, bit 7 enables transmit DMA, and bits 4:0 set the almost-empty level. After reset the levels are 31 and 0.
- R14: A start pulse empties the buffer, clears `xfer_done`, sets `busy`, and latches the direction (1 = receive from the card).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_len_we | input | 1 | Load block length |
| cfg_len | input | 11 | Block length minus one, in bytes |
| cfg_cnt_we | input | 1 | Load block count |
| cfg_cnt | input | 11 | Block count minus one |
| cfg_buf_we | input | 1 | Load threshold and DMA configuration |
| cfg_buf | input | 16 | Threshold and DMA configuration word |
| xfer_start | input | 1 | Start pulse for a transfer |
| xfer_rx | input | 1 | Direction latched at start (1 = receive) |
| host_wr_en | input | 1 | Host pushes a word |
| host_wr_data | input | 16 | Word pushed by the host |
| host_rd_en | input | 1 | Host pops a word |
| host_rd_data | output | 16 | Word at the read position |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Buffer accepts a card byte |
| card_tx_valid | output | 1 | Byte available for the card |
| card_tx_data | output | 8 | Byte toward the card |
| card_tx_ready | input | 1 | Card accepts a byte |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| flag_rx_level | output | 1 | Receive level flag (DMA disabled) |
| flag_tx_level | output | 1 | Transmit level flag (DMA disabled) |
| xfer_done | output | 1 | Sticky end-of-transfer flag |
| busy | output | 1 | Transfer active |
| fill_count | output | 6 | Words held |
| bytes_left | output | 12 | Bytes left in the current block |
| blocks_left | output | 12 | Blocks left in the transfer |

## Verification
The two counters are visible on their own ports. A wrong byte or block count therefore shows on the first block boundary, and also in when `busy` falls. A fault in the half-word state shows up at once, as a byte placed in the wrong half or a byte duplicated in the card-side sequence. The scoreboard catches this on the next handshake. A fault in the pointers or the fill count changes which word the host reads, or when ready and valid gate. This shows within one word's traffic, and the wrap and full cases exercise it at the 32-entry boundary.

// File: rtl/blk_word_fifo.sv
module blk_word_fifo #(
  parameter int AW = 5,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_len_we,
  input  logic [CW-1:0] cfg_len,
  input  logic          cfg_cnt_we,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          cfg_buf_we,
  input  logic [15:0]   cfg_buf,
  input  logic          xfer_start,
  input  logic          xfer_rx,
  input  logic          host_wr_en,
  input  logic [15:0]   host_wr_data,
  input  logic          host_rd_en,
  output logic [15:0]   host_rd_data,
  input  logic          card_rx_valid,
  input  logic [7:0]    card_rx_data,
  output logic          card_rx_ready,
  output logic          card_tx_valid,
  output logic [7:0]    card_tx_data,
  input  logic          card_tx_ready,
  output logic          dma_rx_req,
  output logic          dma_tx_req,
  output logic          flag_rx_level,
  output logic          flag_tx_level,
  output logic          xfer_done,
  output logic          busy,
  output logic [AW:0]   fill_count,
  output logic [CW:0]   bytes_left,
  output logic [CW:0]   blocks_left
);
  localparam int DEPTH = 1 << AW;
  localparam int NW = CW + 1;
  localparam logic [AW:0] FULL = DEPTH[AW:0];

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, af_lvl, ae_lvl;
  logic [AW:0]   count;
  logic          half, active, dir_r, done_r, rx_dma_en, tx_dma_en;
  logic [NW-1:0] blen, nblk, bcnt, kcnt;

  logic rx_hs, tx_hs, byte_ev, last_byte, rx_commit, tx_pop;
  logic host_push, host_pop, push, pop, xfer_live, rx_cond, tx_cond;

  assign last_byte     = (bcnt == NW'(1));
  assign card_rx_ready = active & dir_r & ~host_wr_en & (half | (count <= {1'b0, af_lvl}));
  assign card_tx_valid = active & ~dir_r & ~host_rd_en & (count != '0);
  assign card_tx_data  = half ? mem[rd_ptr][15:8] : mem[rd_ptr][7:0];
  assign host_rd_data  = mem[rd_ptr];

  assign rx_hs     = card_rx_valid & card_rx_ready;
  assign tx_hs     = card_tx_valid & card_tx_ready;
  assign byte_ev   = rx_hs | tx_hs;
  assign rx_commit = rx_hs & (half | last_byte);
  assign tx_pop    = tx_hs & (half | last_byte);
  assign host_push = host_wr_en & (count != FULL);
  assign host_pop  = host_rd_en & (count != '0);
  assign push      = host_push | rx_commit;
  assign pop       = host_pop | tx_pop;

  assign xfer_live     = active | (count != '0);
  assign rx_cond       = xfer_live & dir_r & (count > {1'b0, af_lvl});
  assign tx_cond       = xfer_live & ~dir_r & (count < {1'b0, ae_lvl});
  assign dma_rx_req    = rx_cond & rx_dma_en;
  assign flag_rx_level = rx_cond & ~rx_dma_en;
  assign dma_tx_req    = tx_cond & tx_dma_en;
  assign flag_tx_level = tx_cond & ~tx_dma_en;

  assign xfer_done   = done_r;
  assign busy        = active;
  assign fill_count  = count;
  assign bytes_left  = bcnt;
  assign blocks_left = kcnt;

  always_ff @(posedge clk) begin
    if (host_push)
      mem[wr_ptr] <= host_wr_data;
    else if (rx_hs && !half)
      mem[wr_ptr] <= {8'h00, card_rx_data};
    else if (rx_hs)
      mem[wr_ptr][15:8] <= card_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; half <= 1'b0;
      active <= 1'b0; dir_r <= 1'b0; done_r <= 1'b0;
      rx_dma_en <= 1'b0; tx_dma_en <= 1'b0;
      af_lvl <= '1; ae_lvl <= '0;
      blen <= NW'(1); nblk <= NW'(1); bcnt <= NW'(1); kcnt <= NW'(1);
    end else begin
      if (cfg_buf_we) begin
        rx_dma_en <= cfg_buf[15];
        af_lvl    <= cfg_buf[8 +: AW];
        tx_dma_en <= cfg_buf[7];
        ae_lvl    <= cfg_buf[0 +: AW];
      end
      if (cfg_len_we) begin
        blen <= NW'(cfg_len) + NW'(1);
        bcnt <= NW'(cfg_len) + NW'(1);
      end
      if (cfg_cnt_we) begin
        nblk <= NW'(cfg_cnt) + NW'(1);
        kcnt <= NW'(cfg_cnt) + NW'(1);
        bcnt <= cfg_len_we ? NW'(cfg_len) + NW'(1) : blen;
      end
      if (xfer_start) begin
        wr_ptr <= '0; rd_ptr <= '0; count <= '0; half <= 1'b0;
        active <= 1'b1; dir_r <= xfer_rx; done_r <= 1'b0;
      end else begin
        if (push) wr_ptr <= wr_ptr + 1'b1;
        if (pop)  rd_ptr <= rd_ptr + 1'b1;
        if (push && !pop) count <= count + 1'b1;
        else if (pop && !push) count <= count - 1'b1;
        if (byte_ev) begin
          half <= ~half & ~last_byte;
          if (last_byte) begin
            bcnt <= blen;
            if (kcnt == NW'(1)) begin
              kcnt   <= nblk;
              active <= 1'b0;
              done_r <= 1'b1;
            end else begin
              kcnt <= kcnt - 1'b1;
            end
          end else begin
            bcnt <= bcnt - 1'b1;
          end
        end
      end
    end
  end

  logic [AW-1:0] ptr_gap;
  assign ptr_gap = wr_ptr - rd_ptr;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) fill_count <= FULL);
  a_r2_ptr_track: assert property (@(posedge clk) disable iff (!rst_n) ptr_gap == fill_count[AW-1:0]);
  a_r10_rx_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(dma_rx_req && flag_rx_level));
  a_r11_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(dma_tx_req && flag_tx_level));
  a_r9_done_stops: assert property (@(posedge clk) disable iff (!rst_n) $rose(xfer_done) |-> !busy);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fill_count == '0) |-> !(dma_rx_req || dma_tx_req || flag_rx_level || flag_tx_level));
  a_r14_start_empties: assert property (@(posedge clk) disable iff (!rst_n) xfer_start |=> (fill_count == '0 && busy));
endmodule

// File: tb/blk_word_fifo_bench.sv
`timescale 1ns/1ps
module blk_word_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_len_we = 0, cfg_cnt_we = 0, cfg_buf_we = 0;
  logic [10:0] cfg_len = 0, cfg_cnt = 0;
  logic [15:0] cfg_buf = 0;
  logic xfer_start = 0, xfer_rx = 0;
  logic host_wr_en = 0, host_rd_en = 0;
  logic [15:0] host_wr_data = 0, host_rd_data;
  logic card_rx_valid = 0, card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0] card_rx_data = 0, card_tx_data;
  logic dma_rx_req, dma_tx_req, flag_rx_level, flag_tx_level, xfer_done, busy;
  logic [5:0] fill_count;
  logic [11:0] bytes_left, blocks_left;

  int total = 0, bad = 0;
  logic [7:0]  exp_b[$];
  logic [15:0] exp_w[$];

  always #2.5 clk = ~clk;

  blk_word_fifo u_blk_word_fifo (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic set_buf(input bit rxen, input int af, input bit txen, input int ae);
    tick(); cfg_buf_we = 1; cfg_buf = {rxen, 2'b00, 5'(af), txen, 2'b00, 5'(ae)};
    tick(); cfg_buf_we = 0;
  endtask

  task automatic set_blocks(input int len_m1, input int cnt_m1);
    tick(); cfg_len_we = 1; cfg_len = 11'(len_m1);
    tick(); cfg_len_we = 0; cfg_cnt_we = 1; cfg_cnt = 11'(cnt_m1);
    tick(); cfg_cnt_we = 0;
  endtask

  task automatic start(input bit rx);
    tick(); xfer_start = 1; xfer_rx = rx;
    tick(); xfer_start = 0;
  endtask

  task automatic host_write(input logic [15:0] d, input bit expect_kept);
    tick(); host_wr_en = 1; host_wr_data = d;
    if (expect_kept) exp_w.push_back(d);
    tick(); host_wr_en = 0;
  endtask

  task automatic host_read(input string tag);
    logic [15:0] e;
    tick(); host_rd_en = 1;
    @(negedge clk);
    e = exp_w.size() ? exp_w.pop_front() : 16'hxxxx;
    chk(host_rd_data === e, tag, host_rd_data, e);
    tick(); host_rd_en = 0;
  endtask

  task automatic card_send(input logic [7:0] b);
    tick(); card_rx_valid = 1; card_rx_data = b;
    forever begin
      @(negedge clk);
      if (card_rx_ready) break;
    end
    tick(); card_rx_valid = 0;
  endtask

  task automatic tx_word(input logic [15:0] d, input bit skip_hi);
    host_write(d, 0);
    exp_b.push_back(d[7:0]);
    if (!skip_hi) exp_b.push_back(d[15:8]);
  endtask

  always @(negedge clk) begin
    if (card_tx_valid && card_tx_ready) begin
      if (exp_b.size() == 0) chk(0, "R5 unexpected tx byte", card_tx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_b.pop_front();
        chk(card_tx_data === e, "R5 tx byte order", card_tx_data, e);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(fill_count == 0 && !busy && !xfer_done, "R1 reset state", {fill_count, busy, xfer_done}, 0);
    chk(!card_rx_ready && !card_tx_valid && !dma_rx_req && !dma_tx_req && !flag_rx_level && !flag_tx_level,
        "R1 reset outputs low", {card_rx_ready, card_tx_valid, dma_rx_req, dma_tx_req, flag_rx_level, flag_tx_level}, 0);
    chk(bytes_left == 1 && blocks_left == 1, "R1 reset counters", {bytes_left, blocks_left}, {12'd1, 12'd1});

    // transmit: 2 blocks of 5 bytes
    set_blocks(4, 1);
    @(negedge clk);
    chk(bytes_left == 5 && blocks_left == 2, "R8 block load", {bytes_left, blocks_left}, {12'd5, 12'd2});
    start(0);
    card_tx_ready = 1;
    @(negedge clk);
    chk(!card_tx_valid, "R7 no tx while empty", card_tx_valid, 0);
    tick(); card_tx_ready = 0;
    tx_word(16'h2211, 0); tx_word(16'h4433, 0); tx_word(16'h6655, 1);
    tx_word(16'h8877, 0); tx_word(16'hAA99, 0); tx_word(16'hCCBB, 1);
    set_buf(0, 31, 0, 8);
    @(negedge clk);
    chk(flag_tx_level && !dma_tx_req, "R11 tx flag", {flag_tx_level, dma_tx_req}, 2'b10);
    set_buf(0, 31, 1, 8);
    @(negedge clk);
    chk(!flag_tx_level && dma_tx_req, "R11 R13 tx dma", {flag_tx_level, dma_tx_req}, 2'b01);
    set_buf(0, 31, 0, 0);
    @(negedge clk);
    chk(!flag_tx_level && !dma_tx_req, "R11 condition false", {flag_tx_level, dma_tx_req}, 0);
    tick(); card_tx_ready = 1;
    while (busy) @(negedge clk);
    chk(exp_b.size() == 0, "R5 all bytes sent", exp_b.size(), 0);
    chk(xfer_done && fill_count == 0, "R9 tx done", {xfer_done, fill_count}, {1'b1, 6'd0});
    chk(bytes_left == 5 && blocks_left == 2, "R9 counters reload", {bytes_left, blocks_left}, {12'd5, 12'd2});
    tick(); card_tx_ready = 0;

    // receive: 2 blocks of 3 bytes, almost-full 2
    set_blocks(2, 1);
    set_buf(0, 2, 0, 0);
    start(1);
    @(negedge clk);
    chk(!xfer_done && busy && card_rx_ready, "R14 start rx", {xfer_done, busy, card_rx_ready}, 3'b011);
    card_send(8'h01); card_send(8'h02); card_send(8'h03);
    @(negedge clk);
    chk(bytes_left == 3 && blocks_left == 1, "R9 block step", {bytes_left, blocks_left}, {12'd3, 12'd1});
    card_send(8'h04); card_send(8'h05);
    exp_w.push_back(16'h0201); exp_w.push_back(16'h0003); exp_w.push_back(16'h0504);
    @(negedge clk);
    chk(fill_count == 3 && !card_rx_ready, "R6 rx pause", {fill_count, card_rx_ready}, {6'd3, 1'b0});
    chk(flag_rx_level && !dma_rx_req, "R10 rx flag", {flag_rx_level, dma_rx_req}, 2'b10);
    set_buf(1, 2, 0, 0);
    @(negedge clk);
    chk(!flag_rx_level && dma_rx_req, "R10 R13 rx dma", {flag_rx_level, dma_rx_req}, 2'b01);
    host_read("R4 rx word pack");
    @(negedge clk);
    chk(card_rx_ready && !dma_rx_req, "R6 R10 rx resume", {card_rx_ready, dma_rx_req}, 2'b10);
    card_send(8'h06);
    exp_w.push_back(16'h0006);
    @(negedge clk);
    chk(xfer_done && !busy, "R9 rx done", {xfer_done, busy}, 2'b10);
    host_read("R4 odd byte alone");
    host_read("R4 rx word pack");
    host_read("R4 last odd byte");
    @(negedge clk);
    chk(!dma_rx_req && !dma_tx_req && !flag_rx_level && !flag_tx_level, "R12 idle quiet",
        {dma_rx_req, dma_tx_req, flag_rx_level, flag_tx_level}, 0);

    // full, drop and wrap
    set_buf(0, 31, 0, 0);
    start(0);
    for (int i = 0; i < 33; i++) host_write(16'hA000 + 16'(i), i < 32);
    @(negedge clk);
    chk(fill_count == 32, "R2 full drop", fill_count, 32);
    for (int i = 0; i < 32; i++) host_read("R2 order");
    for (int i = 0; i < 10; i++) host_write(16'hB000 + 16'(i), 1);
    for (int i = 0; i < 10; i++) host_read("R2 wrap order");
    exp_w.push_back(16'hA00A);
    host_read("R3 empty read head");
    @(negedge clk);
    chk(fill_count == 0, "R3 no pop on empty", fill_count, 0);
    host_write(16'h1111, 0); host_write(16'h2222, 0);
    start(1);
    @(negedge clk);
    chk(fill_count == 0 && busy && card_rx_ready, "R14 restart clears", {fill_count, busy, card_rx_ready}, {6'd0, 2'b11});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule